// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down counters. All three advance on a shared count-clock enable, `cnt_tick`, which is sampled on the system clock. A byte-wide register bus reaches four ports. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is a control port that all channels share.

A control byte picks a channel and one of four access modes: snapshot, low byte only, high byte only, or low byte followed by high byte. It also sets the channel's operating mode and chooses binary or BCD counting. Each channel drives one output pin, which either marks a terminal count, gives a periodic one-tick strobe, or gives a square wave.

Software can freeze a channel's running value with a snapshot command. It then reads the frozen value back through the data port while the channel keeps counting.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every channel is in terminal-count mode with binary counting and low-then-high access. Its count is 0, it is stopped, and `tmr_out` is all zero.
- R2: A write to address 3 targets the channel named by bits 7:6 (00, 01 or 10). The value 11 leaves every channel unchanged. Bits 5:4 give the access mode: 00 snapshot, 01 low only, 10 high only, 11 low then high. Bits 3:1 give the mode, and bit 0 set selects BCD.
- R3: In low-only access, one data write sets the reload to {8'h00, byte}. In high-only access, one data write sets it to {byte, 8'h00}. Reads in these modes return only that byte.
- R4: In low-then-high access, the first data write supplies the low byte and the second supplies the high byte. The channel does not start until the second write. A nonzero-access control write returns both byte pointers to the low byte, stops the channel and drives its output to the idle level: low for terminal-count mode, high for the other two modes.
- R5: After a complete reload write, the next count tick loads the reload value. Each later tick steps the count down by one.
- R6: In terminal-count mode (mode code with bits 2:1 of the field not equal to 01 or 11), the output is low until a tick takes the count from 1 to 0. It then stays high while the counter wraps, until a control write or a new complete reload.
- R7: In rate mode (mode code 010), the output is low exactly while the count equals 1. The tick after that reloads the count, so the period is N ticks.
- R8: In square mode (mode code 011), the output is high while the count in ticks is greater than half of N (rounded down). For odd N the high phase is one tick longer than the low phase.
- R9: A reload value of 0 stands for 65536 ticks in binary and 10000 ticks in BCD. A count of 0 steps to FFFF in binary and to 9999 in BCD.
- R10: In BCD, each of the four nibbles counts 9 down to 0 and borrows from the nibble above it (for example 0100 steps to 0099).
- R11: A snapshot command (access 00) copies the live count. Reads of that data port return the copy while counting goes on. The copy is released after its last byte has been read: one read in single-byte access, two reads in low-then-high access.
- R12: A snapshot command that arrives while a copy is still held is ignored, and the held copy is kept.
- R13: Without a snapshot, data-port reads return the live count. Reads never change the count.
- R14: Mode codes 000, 001, 100 and 101 all behave as terminal-count mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Count-clock enable, one tick per high cycle |
| bus_addr | input | 2 | Port address: 0..2 data, 3 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; advances the read byte pointer |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed data port |
| tmr_out | output | NUM_CH | One output pin per channel |

## Verification
The bench builds the timer with its default of three channels and the full 16-bit counter width. That lets it drive all three channels from the shared tick while each one runs in a different mode, and it lets the channel-select field be checked with one channel watching another. At full width the BCD zero reload gives a period of 10000 ticks, which is short enough to run end to end. The binary zero reload is 65536 ticks, so it is covered through its first wrap step rather than a whole period.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned SPAN_W = CNT_W + 1;
  localparam int unsigned NDIG   = CNT_W / 4;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    OP_TC     = 2'd0,
    OP_RATE   = 2'd1,
    OP_SQUARE = 2'd2
  } op_e;

  function automatic op_e op_of(input logic [2:0] code);
    case (code[1:0])
      2'b10:   return OP_RATE;
      2'b11:   return OP_SQUARE;
      default: return OP_TC;
    endcase
  endfunction

  // One count step down; BCD borrows nibble by nibble, zero wraps to all nines.
  function automatic logic [CNT_W-1:0] dec_count(input logic [CNT_W-1:0] v,
                                                 input logic bcd);
    logic [CNT_W-1:0] r;
    logic             borrow;
    logic [3:0]       dig;
    if (!bcd) begin
      r = v - CNT_W'(1);
    end else begin
      r      = v;
      borrow = 1'b1;
      for (int d = 0; d < NDIG; d++) begin
        dig = r[4*d +: 4];
        if (borrow) begin
          if (dig == 4'd0) dig = 4'd9;
          else begin
            dig    = dig - 4'd1;
            borrow = 1'b0;
          end
        end
        r[4*d +: 4] = dig;
      end
    end
    return r;
  endfunction

  // Number of ticks a stored value stands for; zero means a full wrap.
  function automatic logic [SPAN_W-1:0] span_of(input logic [CNT_W-1:0] v,
                                                input logic bcd);
    logic [SPAN_W-1:0] acc;
    acc = '0;
    if (bcd) begin
      for (int d = NDIG - 1; d >= 0; d--)
        acc = (acc * SPAN_W'(10)) + SPAN_W'(v[4*d +: 4]);
      if (acc == '0) acc = SPAN_W'(10 ** NDIG);
    end else begin
      acc = SPAN_W'(v);
      if (acc == '0) acc = SPAN_W'(1) << CNT_W;
    end
    return acc;
  endfunction
endpackage

// File: rtl/itmr_access_seq.sv
module itmr_access_seq
  import itmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              acc,
  input  logic              cfg_wr,
  input  logic              snap_cmd,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_count,
  output logic [CNT_W-1:0]  reload,
  output logic              reload_done,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              held,
  output logic [CNT_W-1:0]  snap
);
  logic              wr_hi_q, rd_hi_q, held_q;
  logic [BYTE_W-1:0] lo_byte_q;
  logic [CNT_W-1:0]  reload_q, snap_q;
  logic [CNT_W-1:0]  src;
  logic              rd_last, snap_take;

  assign reload_done = data_wr && ((acc != ACC_LOHI) || wr_hi_q);
  assign rd_last     = (acc != ACC_LOHI) || rd_hi_q;
  assign snap_take   = snap_cmd && !held_q;
  assign src         = held_q ? snap_q : live_count;

  always_comb begin
    case (acc)
      ACC_HI:   rd_byte = src[CNT_W-1 -: BYTE_W];
      ACC_LOHI: rd_byte = rd_hi_q ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
      default:  rd_byte = src[BYTE_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      held_q    <= 1'b0;
      lo_byte_q <= '0;
      reload_q  <= '0;
      snap_q    <= '0;
    end else if (cfg_wr) begin
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      held_q  <= 1'b0;
    end else begin
      if (data_wr) begin
        case (acc)
          ACC_LO: reload_q <= {{BYTE_W{1'b0}}, wdata};
          ACC_HI: reload_q <= {wdata, {BYTE_W{1'b0}}};
          default: begin
            if (wr_hi_q) reload_q  <= {wdata, lo_byte_q};
            else         lo_byte_q <= wdata;
            wr_hi_q <= !wr_hi_q;
          end
        endcase
      end
      if (data_rd) begin
        if (acc == ACC_LOHI) rd_hi_q <= !rd_hi_q;
        if (rd_last) held_q <= 1'b0;
      end
      if (snap_take) begin
        snap_q  <= live_count;
        held_q  <= 1'b1;
        rd_hi_q <= 1'b0;
      end
    end
  end

  assign reload = reload_q;
  assign held   = held_q;
  assign snap   = snap_q;
endmodule

// File: rtl/itmr_count_core.sv
module itmr_count_core
  import itmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_wr,
  input  op_e              op,
  input  logic             bcd,
  input  logic             reload_done,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             run,
  output logic             pend,
  output logic             out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  count_q, count_dn;
  logic [SPAN_W-1:0] span_q;
  logic              run_q, pend_q, tc_q, at_one;

  assign count_dn = dec_count(count_q, bcd);
  assign at_one   = (count_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      span_q  <= '0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      tc_q    <= 1'b0;
    end else if (cfg_wr) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      if (tick) begin
        if (pend_q) begin
          count_q <= reload;
          span_q  <= span_of(reload, bcd);
          run_q   <= 1'b1;
          pend_q  <= 1'b0;
        end else if (run_q) begin
          if (op == OP_TC) begin
            count_q <= count_dn;
            if (at_one) tc_q <= 1'b1;
          end else begin
            count_q <= at_one ? reload : count_dn;
          end
        end
      end
      if (reload_done) begin
        pend_q <= 1'b1;
        tc_q   <= 1'b0;
      end
    end
  end

  always_comb begin
    case (op)
      OP_RATE:   out = !run_q || !at_one;
      OP_SQUARE: out = !run_q || (span_of(count_q, bcd) > (span_q >> 1));
      default:   out = tc_q;
    endcase
  end

  assign count = count_q;
  assign run   = run_q;
  assign pend  = pend_q;
endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
  import itmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_wr,
  input  logic [BYTE_W-1:0] cfg_byte,
  input  logic              snap_cmd,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              out,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  snap,
  output logic              held,
  output logic              run,
  output logic              pend,
  output logic              reload_done,
  output op_e               op
);
  acc_e acc_q;
  op_e  op_q;
  logic bcd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= ACC_LOHI;
      op_q  <= OP_TC;
      bcd_q <= 1'b0;
    end else if (cfg_wr) begin
      acc_q <= acc_e'(cfg_byte[5:4]);
      op_q  <= op_of(cfg_byte[3:1]);
      bcd_q <= cfg_byte[0];
    end
  end

  itmr_access_seq seq_i (
    .clk(clk), .rst_n(rst_n), .acc(acc_q), .cfg_wr(cfg_wr),
    .snap_cmd(snap_cmd), .data_wr(data_wr), .data_rd(data_rd),
    .wdata(wdata), .live_count(count), .reload(reload),
    .reload_done(reload_done), .rd_byte(rd_byte), .held(held), .snap(snap)
  );

  itmr_count_core core_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr), .op(op_q),
    .bcd(bcd_q), .reload_done(reload_done), .reload(reload),
    .count(count), .run(run), .pend(pend), .out(out)
  );

  assign op = op_q;
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] tmr_out
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic              ctrl_hit;
  logic [BYTE_W-1:0] ch_rd     [NUM_CH];
  logic [CNT_W-1:0]  ch_count  [NUM_CH];
  logic [CNT_W-1:0]  ch_reload [NUM_CH];
  logic [CNT_W-1:0]  ch_snap   [NUM_CH];
  logic              ch_held   [NUM_CH];
  logic              ch_run    [NUM_CH];
  logic              ch_pend   [NUM_CH];
  logic              ch_done   [NUM_CH];
  logic              ch_cfg_wr [NUM_CH];
  logic              ch_snap_cmd [NUM_CH];
  logic              ch_out    [NUM_CH];
  op_e               ch_op     [NUM_CH];

  assign ctrl_hit = bus_wr && (bus_addr == CTRL_ADDR);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel_me;
    assign sel_me          = ctrl_hit && (bus_wdata[7:6] == 2'(i));
    assign ch_cfg_wr[i]    = sel_me && (bus_wdata[5:4] != 2'b00);
    assign ch_snap_cmd[i]  = sel_me && (bus_wdata[5:4] == 2'b00);

    itmr_channel chan_i (
      .clk(clk), .rst_n(rst_n), .tick(cnt_tick),
      .cfg_wr(ch_cfg_wr[i]), .cfg_byte(bus_wdata), .snap_cmd(ch_snap_cmd[i]),
      .data_wr(bus_wr && (bus_addr == 2'(i))),
      .data_rd(bus_rd && (bus_addr == 2'(i))),
      .wdata(bus_wdata), .rd_byte(ch_rd[i]), .out(ch_out[i]),
      .count(ch_count[i]), .reload(ch_reload[i]), .snap(ch_snap[i]),
      .held(ch_held[i]), .run(ch_run[i]), .pend(ch_pend[i]),
      .reload_done(ch_done[i]), .op(ch_op[i])
    );
    assign tmr_out[i] = ch_out[i];
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (bus_addr == 2'(i)) bus_rdata = ch_rd[i];
  end
endmodule

// File: rtl/itmr_checks.sv
module itmr_checks
  import itmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_tick,
  input logic [CNT_W-1:0] ch_count  [NUM_CH],
  input logic [CNT_W-1:0] ch_reload [NUM_CH],
  input logic [CNT_W-1:0] ch_snap   [NUM_CH],
  input logic             ch_held   [NUM_CH],
  input logic             ch_run    [NUM_CH],
  input logic             ch_pend   [NUM_CH],
  input logic             ch_done   [NUM_CH],
  input logic             ch_cfg_wr [NUM_CH],
  input logic             ch_out    [NUM_CH],
  input op_e              ch_op     [NUM_CH]
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r5_load_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_pend[i] && cnt_tick && !ch_cfg_wr[i])
      |=> (ch_run[i] && ch_count[i] == $past(ch_reload[i])));

    a_r6_terminal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_op[i] == OP_TC && ch_out[i] && !ch_cfg_wr[i] && !ch_done[i])
      |=> ch_out[i]);

    a_r7_rate_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_op[i] == OP_RATE && ch_run[i] && !ch_pend[i] && cnt_tick &&
       ch_count[i] == CNT_W'(1) && !ch_cfg_wr[i])
      |=> (ch_count[i] == $past(ch_reload[i])));

    a_r11_snapshot_capture: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_held[i]) |-> (ch_snap[i] == $past(ch_count[i])));

    a_r12_snapshot_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_held[i] && !ch_cfg_wr[i]) |=> (!ch_held[i] || $stable(ch_snap[i])));

    a_r13_count_idle_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_tick) |=> $stable(ch_count[i]));
  end
endmodule

bind tri_interval_timer itmr_checks #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
  .ch_count(ch_count), .ch_reload(ch_reload), .ch_snap(ch_snap),
  .ch_held(ch_held), .ch_run(ch_run), .ch_pend(ch_pend), .ch_done(ch_done),
  .ch_cfg_wr(ch_cfg_wr), .ch_out(ch_out), .ch_op(ch_op)
);

// File: tb/tri_interval_timer_tb_top.sv
module tri_interval_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_tick = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] tmr_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tri_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tmr_out(tmr_out)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 outputs after reset", int'(tmr_out), 0);
    rd16(2'd0, v);
    chk("R1 count after reset", int'(v), 0);
  endtask

  task automatic t_two_step_load;
    logic [15:0] v;
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h07);
    ticks(3);
    chk("R4 idle high before high byte", int'(tmr_out[0]), 1);
    rd16(2'd0, v);
    chk("R4 no count before high byte", int'(v), 0);
    wr(2'd0, 8'h00);
    ticks(1);
    rd16(2'd0, v);
    chk("R5 reload loaded on first tick", int'(v), 16'h0007);
    rd16(2'd0, v);
    chk("R13 read does not disturb count", int'(v), 16'h0007);
  endtask

  task automatic t_select;
    logic [15:0] v;
    wr(2'd3, 8'h74);
    chk("R2 channel 1 selected, idle high", int'(tmr_out[1]), 1);
    wr(2'd3, 8'hF0);
    chk("R2 select 11 ignored", int'(tmr_out), 3'b011);
    rd16(2'd0, v);
    chk("R2 channel 0 untouched", int'(v), 16'h0007);
  endtask

  task automatic t_terminal;
    wr(2'd3, 8'h30);
    chk("R6 idle low", int'(tmr_out[0]), 0);
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    ticks(1);
    ticks(2);
    chk("R6 low at count 1", int'(tmr_out[0]), 0);
    ticks(1);
    chk("R6 high at count 0", int'(tmr_out[0]), 1);
    ticks(3);
    chk("R6 stays high while wrapping", int'(tmr_out[0]), 1);
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    chk("R6 new count drives low", int'(tmr_out[0]), 0);
  endtask

  task automatic t_alias_mode;
    wr(2'd3, 8'h32);
    chk("R14 code 001 idles low", int'(tmr_out[0]), 0);
    wr(2'd0, 8'h02); wr(2'd0, 8'h00);
    ticks(2);
    chk("R14 low at count 1", int'(tmr_out[0]), 0);
    ticks(1);
    chk("R14 high at terminal", int'(tmr_out[0]), 1);
  endtask

  task automatic t_rate;
    logic [7:0] seen;
    wr(2'd3, 8'h74);
    wr(2'd1, 8'h04); wr(2'd1, 8'h00);
    ticks(1);
    for (int k = 0; k < 7; k++) begin
      ticks(1);
      seen[k] = tmr_out[1];
    end
    chk("R7 one-tick low per period of 4", int'(seen[6:0]), 7'b0111011);
  endtask

  task automatic t_square(input logic [7:0] n, input logic [9:0] exp);
    logic [9:0] seen;
    wr(2'd3, 8'hB6);
    wr(2'd2, n); wr(2'd2, 8'h00);
    for (int k = 0; k < 10; k++) begin
      ticks(1);
      seen[9-k] = tmr_out[2];
    end
    chk("R8 square wave shape", int'(seen), int'(exp));
  endtask

  task automatic t_zero_reload;
    logic [15:0] v;
    wr(2'd3, 8'h74);
    wr(2'd1, 8'h00); wr(2'd1, 8'h00);
    ticks(1);
    rd16(2'd1, v);
    chk("R9 binary zero loaded", int'(v), 0);
    ticks(1);
    rd16(2'd1, v);
    chk("R9 binary 0 steps to FFFF", int'(v), 16'hFFFF);
    wr(2'd3, 8'h35);
    wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    ticks(1);
    ticks(9998);
    rd16(2'd0, v);
    chk("R9 BCD 10000 minus 9998", int'(v), 16'h0002);
    chk("R9 BCD still high at 2", int'(tmr_out[0]), 1);
    ticks(1);
    chk("R9 BCD low at tick 9999", int'(tmr_out[0]), 0);
    ticks(1);
    chk("R9 BCD reload after 10000", int'(tmr_out[0]), 1);
  endtask

  task automatic t_bcd;
    logic [15:0] v;
    wr(2'd3, 8'h31);
    wr(2'd0, 8'h00); wr(2'd0, 8'h01);
    ticks(2);
    rd16(2'd0, v);
    chk("R10 BCD 0100 steps to 0099", int'(v), 16'h0099);
    ticks(98);
    rd16(2'd0, v);
    chk("R10 BCD reaches 0001", int'(v), 16'h0001);
    ticks(1);
    chk("R10 BCD terminal count", int'(tmr_out[0]), 1);
  endtask

  task automatic t_snapshot;
    logic [15:0] v;
    logic [7:0]  b;
    wr(2'd3, 8'h74);
    wr(2'd1, 8'h34); wr(2'd1, 8'h12);
    ticks(5);
    wr(2'd3, 8'h40);
    ticks(3);
    rd16(2'd1, v);
    chk("R11 snapshot value", int'(v), 16'h1230);
    rd16(2'd1, v);
    chk("R11 released after two reads", int'(v), 16'h122D);
    wr(2'd3, 8'h40);
    ticks(2);
    wr(2'd3, 8'h40);
    ticks(1);
    rd16(2'd1, v);
    chk("R12 second snapshot ignored", int'(v), 16'h122D);
    rd16(2'd1, v);
    chk("R12 live after release", int'(v), 16'h122A);
    wr(2'd3, 8'h94);
    wr(2'd2, 8'h50);
    ticks(2);
    wr(2'd3, 8'h80);
    ticks(2);
    rd(2'd2, b);
    chk("R11 single-byte snapshot", int'(b), 8'h4F);
    rd(2'd2, b);
    chk("R11 single-byte released after one read", int'(b), 8'h4D);
  endtask

  task automatic t_single_byte;
    logic [7:0] b;
    wr(2'd3, 8'h94);
    wr(2'd2, 8'h05);
    ticks(1);
    rd(2'd2, b);
    chk("R3 low-only load", int'(b), 8'h05);
    wr(2'd3, 8'hA4);
    wr(2'd2, 8'h02);
    ticks(1);
    rd(2'd2, b);
    chk("R3 high-only load gives 0200", int'(b), 8'h02);
    ticks(1);
    rd(2'd2, b);
    chk("R3 high byte of 01FF", int'(b), 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_two_step_load();
    t_select();
    t_terminal();
    t_alias_mode();
    t_rate();
    t_square(8'h05, 10'b1110011100);
    t_square(8'h04, 10'b1100110011);
    t_zero_reload();
    t_bcd();
    t_snapshot();
    t_single_byte();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule